// File: doc/BRIEF.md
# Protected-Range Memory Router

This block sits between the processor's uncached access path and two memory targets: a DRAM port and a VGA port. Each access that reaches it carries an address, a write flag and write data, and is steered to exactly one of the two targets. One address window, bounded by a programmable base and end (both inclusive), is treated as a protected region reserved for code that runs in the processor's privileged mode. When that region is touched from the ordinary mode, the access is diverted to the VGA port, so the DRAM behind the region can be neither read nor overwritten from outside the privileged mode.

A small control register decides how strict this is. An open bit, when set, lets ordinary-mode accesses reach the DRAM behind the region, which is how boot code fills it. A lock bit, once set, freezes the open bit and the range bounds until reset. Setting the lock also clears the open bit. Commands refused because of the lock produce a one-cycle error pulse. A configuration flag reports when the programmed region is too small to contain the privileged-mode entry point at base + 0x8000.

Requests pass through a single registered slot. The target is decided in the cycle the request is accepted and is held on the chosen port until that port accepts it.

Top module: `smram_router`

## Requirements
- R1: After reset, open and lock are 0, the command error pulse is 0, the bounds hold their reset defaults (0x30000 and 0x3FFFF) so the configuration error flag is 0, neither target port is valid, and the request input is ready.
- R2: A request whose address lies in [base, end], accepted while the privileged-mode input is 0 and the open bit is 0, appears on the VGA port only.
- R3: A request in [base, end] accepted while the privileged-mode input is 1 appears on the DRAM port only, whatever the open bit.
- R4: A request in [base, end] accepted in ordinary mode while the open bit is 1 appears on the DRAM port only.
- R5: A request outside [base, end] goes to the VGA port when its address lies in the fixed window [0xA0000, 0xBFFFF] and to the DRAM port otherwise; the protected range takes precedence where the two overlap.
- R6: Command code 2'b10 inverts the open bit while lock is 0; while lock is 1 it leaves the open bit unchanged and raises the error output for exactly one cycle.
- R7: Command code 2'b11 while lock is 0 sets lock to 1 and clears open; lock then stays 1 until reset, and a further 2'b11 is refused with a one-cycle error pulse.
- R8: Command codes 2'b00 and 2'b01 load the command data into base and end respectively while lock is 0; while lock is 1 they leave the bounds unchanged and pulse the error output.
- R9: The configuration error flag is 1 exactly when end is not greater than base or end - base is not greater than 0x8000.
- R10: At most one target port is valid at a time; a pending request keeps its address, write flag and data stable on its port, and the request input stays not ready, until that port's ready is seen high.
- R11: The address, write flag and write data appear unchanged on the chosen port in the cycle after the clock edge that accepts the request, and a command's effect on open, lock, bounds and the error pulse is visible in the cycle after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| priv_mode | input | 1 | 1 while the processor runs in its privileged mode |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this edge when both are high |
| req_addr | input | ADDR_W | Physical address of the access |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | DATA_W | Write data |
| cmd_valid | input | 1 | Control command present |
| cmd_op | input | 2 | 00 set base, 01 set end, 10 flip open, 11 lock |
| cmd_data | input | ADDR_W | Bound value for codes 00 and 01 |
| dram_valid | output | 1 | Request valid on the DRAM port |
| dram_ready | input | 1 | DRAM port accepts |
| dram_addr | output | ADDR_W | DRAM port address |
| dram_we | output | 1 | DRAM port write flag |
| dram_wdata | output | DATA_W | DRAM port write data |
| vga_valid | output | 1 | Request valid on the VGA port |
| vga_ready | input | 1 | VGA port accepts |
| vga_addr | output | ADDR_W | VGA port address |
| vga_we | output | 1 | VGA port write flag |
| vga_wdata | output | DATA_W | VGA port write data |
| open_bit | output | 1 | Current open bit |
| lock_bit | output | 1 | Current lock bit |
| range_base | output | ADDR_W | Current protected-range base |
| range_end | output | ADDR_W | Current protected-range end |
| cfg_err | output | 1 | Protected range too small or inverted |
| cmd_err | output | 1 | One-cycle pulse after a command refused by the lock |

## Verification
A routed request is due on its port one cycle after its accepting edge, and register updates and the refusal pulse are due one cycle after the command's edge; the configuration flag follows the bounds with no further delay. The bench drives every input on the falling edge and reads results on the next falling edge, so each check lands exactly in the cycle after the edge that produced the result, and it checks the pulse again one cycle later to confirm it lasted one cycle. For backpressure it holds a port's ready low over several falling-edge samples and checks that the request stays put, then raises ready and confirms the port empties on the next edge.

// File: rtl/smram_router_pkg.sv
`timescale 1ns/1ps
package smram_router_pkg;
  typedef enum logic [1:0] {
    OP_SET_BASE  = 2'b00,
    OP_SET_END   = 2'b01,
    OP_FLIP_OPEN = 2'b10,
    OP_LOCK      = 2'b11
  } cfg_op_e;

  typedef enum logic {
    TGT_DRAM = 1'b0,
    TGT_VGA  = 1'b1
  } target_e;
endpackage

// File: rtl/smram_cfg_regs.sv
`timescale 1ns/1ps
module smram_cfg_regs
  import smram_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RST_BASE = 'h30000,
  parameter logic [ADDR_W-1:0] RST_END  = 'h3FFFF,
  parameter int unsigned ENTRY_OFS = 'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_data,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] end_o,
  output logic              open_o,
  output logic              lock_o,
  output logic              cmd_err_o,
  output logic              cfg_err_o
);
  localparam logic [ADDR_W-1:0] MinSpan = ADDR_W'(ENTRY_OFS);

  logic [ADDR_W-1:0] base_q, base_d, end_q, end_d;
  logic              open_q, open_d, lock_q, lock_d, err_q, err_d;
  logic [ADDR_W-1:0] span;

  always_comb begin
    base_d = base_q;
    end_d  = end_q;
    open_d = open_q;
    lock_d = lock_q;
    err_d  = 1'b0;
    if (cmd_valid) begin
      if (lock_q) begin
        err_d = 1'b1;
      end else begin
        unique case (cfg_op_e'(cmd_op))
          OP_SET_BASE:  base_d = cmd_data;
          OP_SET_END:   end_d  = cmd_data;
          OP_FLIP_OPEN: open_d = ~open_q;
          OP_LOCK: begin
            lock_d = 1'b1;
            open_d = 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= RST_BASE;
      end_q  <= RST_END;
      open_q <= 1'b0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      end_q  <= end_d;
      open_q <= open_d;
      lock_q <= lock_d;
      err_q  <= err_d;
    end
  end

  assign span      = end_q - base_q;
  assign cfg_err_o = (end_q <= base_q) || (span <= MinSpan);
  assign base_o    = base_q;
  assign end_o     = end_q;
  assign open_o    = open_q;
  assign lock_o    = lock_q;
  assign cmd_err_o = err_q;

  // R7: lock is sticky until reset
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R7: an accepted lock command clears open
  assert_lock_clears_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !lock_q && cmd_op == 2'b11) |=> (lock_q && !open_q));
  // R6: open is frozen while locked
  assert_open_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(open_q));
  // R8: bounds frozen while locked
  assert_bounds_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(base_q) && $stable(end_q)));
  // R6: a command under lock yields the error pulse
  assert_refused_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && lock_q) |=> err_q);
endmodule

// File: rtl/smram_addr_decode.sv
`timescale 1ns/1ps
module smram_addr_decode
  import smram_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] VGA_LO = 'hA0000,
  parameter logic [ADDR_W-1:0] VGA_HI = 'hBFFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] top,
  input  logic              priv_mode,
  input  logic              open_bit,
  output logic              in_prot,
  output target_e           tgt
);
  logic in_vga;

  assign in_prot = (addr >= base) && (addr <= top);
  assign in_vga  = (addr >= VGA_LO) && (addr <= VGA_HI);

  always_comb begin
    if (in_prot) begin
      tgt = (priv_mode || open_bit) ? TGT_DRAM : TGT_VGA;
    end else if (in_vga) begin
      tgt = TGT_VGA;
    end else begin
      tgt = TGT_DRAM;
    end
  end
endmodule

// File: rtl/smram_route_slot.sv
`timescale 1ns/1ps
module smram_route_slot
  import smram_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_we,
  input  logic [DATA_W-1:0] in_wdata,
  input  target_e           in_tgt,
  output logic              dram_valid_o,
  input  logic              dram_ready,
  output logic              vga_valid_o,
  input  logic              vga_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_we,
  output logic [DATA_W-1:0] out_wdata
);
  logic              vld_q, vld_d;
  target_e           tgt_q, tgt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              drain, accept, load_en;

  assign drain    = vld_q && ((tgt_q == TGT_DRAM) ? dram_ready : vga_ready);
  assign in_ready = !vld_q || drain;
  assign accept   = in_valid && in_ready;
  assign load_en  = accept;

  always_comb begin
    vld_d  = vld_q;
    tgt_d  = tgt_q;
    addr_d = addr_q;
    we_d   = we_q;
    data_d = data_q;
    if (load_en) begin
      vld_d  = 1'b1;
      tgt_d  = in_tgt;
      addr_d = in_addr;
      we_d   = in_we;
      data_d = in_wdata;
    end else if (drain) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      tgt_q  <= tgt_d;
      addr_q <= addr_d;
      we_q   <= we_d;
      data_q <= data_d;
    end
  end

  assign dram_valid_o = vld_q && (tgt_q == TGT_DRAM);
  assign vga_valid_o  = vld_q && (tgt_q == TGT_VGA);
  assign out_addr     = addr_q;
  assign out_we       = we_q;
  assign out_wdata    = data_q;

  // R10: only one target is offered a request
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_valid_o && vga_valid_o));
  // R10: a stalled DRAM request holds still
  assert_hold_dram_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_valid_o && !dram_ready) |=>
      (dram_valid_o && $stable(out_addr) && $stable(out_we) && $stable(out_wdata)));
  // R10: a stalled VGA request holds still
  assert_hold_vga_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vga_valid_o && !vga_ready) |=>
      (vga_valid_o && $stable(out_addr) && $stable(out_we) && $stable(out_wdata)));
endmodule

// File: rtl/smram_router.sv
`timescale 1ns/1ps
module smram_router
  import smram_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ENTRY_OFS = 'h8000,
  parameter logic [ADDR_W-1:0] RST_BASE = 'h30000,
  parameter logic [ADDR_W-1:0] RST_END  = 'h3FFFF,
  parameter logic [ADDR_W-1:0] VGA_LO   = 'hA0000,
  parameter logic [ADDR_W-1:0] VGA_HI   = 'hBFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_data,
  output logic              dram_valid,
  input  logic              dram_ready,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_we,
  output logic [DATA_W-1:0] dram_wdata,
  output logic              vga_valid,
  input  logic              vga_ready,
  output logic [ADDR_W-1:0] vga_addr,
  output logic              vga_we,
  output logic [DATA_W-1:0] vga_wdata,
  output logic              open_bit,
  output logic              lock_bit,
  output logic [ADDR_W-1:0] range_base,
  output logic [ADDR_W-1:0] range_end,
  output logic              cfg_err,
  output logic              cmd_err
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              in_prot;
  target_e           tgt;
  logic [ADDR_W-1:0] slot_addr;
  logic              slot_we;
  logic [DATA_W-1:0] slot_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  smram_cfg_regs #(
    .ADDR_W(ADDR_W), .RST_BASE(RST_BASE), .RST_END(RST_END), .ENTRY_OFS(ENTRY_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .base_o(range_base), .end_o(range_end),
    .open_o(open_bit), .lock_o(lock_bit),
    .cmd_err_o(cmd_err), .cfg_err_o(cfg_err)
  );

  smram_addr_decode #(
    .ADDR_W(ADDR_W), .VGA_LO(VGA_LO), .VGA_HI(VGA_HI)
  ) u_dec (
    .addr(req_addr), .base(range_base), .top(range_end),
    .priv_mode(priv_mode), .open_bit(open_bit),
    .in_prot(in_prot), .tgt(tgt)
  );

  smram_route_slot #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_slot (
    .clk(clk), .rst_n(rst_n_int),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_addr(req_addr), .in_we(req_we), .in_wdata(req_wdata), .in_tgt(tgt),
    .dram_valid_o(dram_valid), .dram_ready(dram_ready),
    .vga_valid_o(vga_valid), .vga_ready(vga_ready),
    .out_addr(slot_addr), .out_we(slot_we), .out_wdata(slot_wdata)
  );

  assign dram_addr  = slot_addr;
  assign dram_we    = slot_we;
  assign dram_wdata = slot_wdata;
  assign vga_addr   = slot_addr;
  assign vga_we     = slot_we;
  assign vga_wdata  = slot_wdata;

  // R2: closed protected access from ordinary mode is diverted to VGA
  assert_divert_vga_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && req_ready && in_prot && !priv_mode && !open_bit) |=> (vga_valid && !dram_valid));
  // R3: privileged protected access reaches DRAM
  assert_priv_dram_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && req_ready && in_prot && priv_mode) |=> (dram_valid && !vga_valid));
  // R4: open bit lets ordinary mode reach DRAM
  assert_open_dram_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && req_ready && in_prot && open_bit) |=> dram_valid);
  // R11: accepted address shows up one cycle later
  assert_addr_passed_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && req_ready) |=> (dram_addr == $past(req_addr)));
endmodule

// File: tb/smram_router_test.sv
`timescale 1ns/1ps
module smram_router_test;
  localparam logic [31:0] VLO = 32'hA0000;
  localparam logic [31:0] VHI = 32'hBFFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        priv_mode, req_valid, req_ready, req_we;
  logic [31:0] req_addr, req_wdata;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_data;
  logic        dram_valid, dram_ready, dram_we, vga_valid, vga_ready, vga_we;
  logic [31:0] dram_addr, dram_wdata, vga_addr, vga_wdata, range_base, range_end;
  logic        open_bit, lock_bit, cfg_err, cmd_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_base, m_end;
  bit          m_open, m_lock;

  always #5 clk = ~clk;

  smram_router uut (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_addr(dram_addr),
    .dram_we(dram_we), .dram_wdata(dram_wdata),
    .vga_valid(vga_valid), .vga_ready(vga_ready), .vga_addr(vga_addr),
    .vga_we(vga_we), .vga_wdata(vga_wdata),
    .open_bit(open_bit), .lock_bit(lock_bit),
    .range_base(range_base), .range_end(range_end),
    .cfg_err(cfg_err), .cmd_err(cmd_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_vga(input logic [31:0] a, input bit pm);
    if (a >= m_base && a <= m_end) return !(pm || m_open);
    return (a >= VLO && a <= VHI);
  endfunction

  function automatic bit exp_cfg_err();
    return (m_end <= m_base) || ((m_end - m_base) <= 32'h8000);
  endfunction

  // drive one request, check its port in the cycle after acceptance (R11)
  task automatic send(input logic [31:0] a, input bit pm, input string req);
    bit v;
    logic [31:0] d;
    d = $urandom;
    v = exp_vga(a, pm);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; priv_mode = pm; req_we = d[0]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(vga_valid == v && dram_valid == !v, req, {30'd0, vga_valid, dram_valid}, {30'd0, v, !v});
    if (v) check(vga_addr == a && vga_we == d[0] && vga_wdata == d, "R11", vga_addr, a);
    else   check(dram_addr == a && dram_we == d[0] && dram_wdata == d, "R11", dram_addr, a);
  endtask

  task automatic command(input logic [1:0] op, input logic [31:0] data, input string req);
    bit refused;
    refused = m_lock;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!m_lock) begin
      case (op)
        2'b00: m_base = data;
        2'b01: m_end = data;
        2'b10: m_open = !m_open;
        default: begin m_lock = 1'b1; m_open = 1'b0; end
      endcase
    end
    check(cmd_err == refused, req, {31'd0, cmd_err}, {31'd0, refused});
    check(open_bit == m_open && lock_bit == m_lock, req, {30'd0, lock_bit, open_bit}, {30'd0, m_lock, m_open});
    check(range_base == m_base && range_end == m_end, "R8", range_base, m_base);
    check(cfg_err == exp_cfg_err(), "R9", {31'd0, cfg_err}, {31'd0, exp_cfg_err()});
    @(negedge clk);
    check(cmd_err == 1'b0, req, {31'd0, cmd_err}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; priv_mode = 1'b0; req_valid = 1'b0; req_addr = '0; req_we = 1'b0;
    req_wdata = '0; cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
    dram_ready = 1'b1; vga_ready = 1'b1;
    m_base = 32'h30000; m_end = 32'h3FFFF; m_open = 1'b0; m_lock = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(!open_bit && !lock_bit && !cmd_err && !cfg_err, "R1",
          {28'd0, open_bit, lock_bit, cmd_err, cfg_err}, 32'd0);
    check(!dram_valid && !vga_valid && req_ready, "R1",
          {29'd0, dram_valid, vga_valid, req_ready}, 32'd1);
    check(range_base == 32'h30000 && range_end == 32'h3FFFF, "R1", range_base, 32'h30000);

    // R2 / R3 / R5 directed, including range edges
    send(32'h30000, 1'b0, "R2");
    send(32'h3FFFF, 1'b0, "R2");
    send(32'h38000, 1'b1, "R3");
    send(32'h30000, 1'b1, "R3");
    send(32'h2FFFF, 1'b0, "R5");
    send(32'h40000, 1'b0, "R5");
    send(VLO, 1'b0, "R5");
    send(VHI, 1'b1, "R5");
    send(32'hC0000, 1'b0, "R5");

    // R4 / R6: open bit
    command(2'b10, 32'd0, "R6");
    send(32'h30010, 1'b0, "R4");
    send(32'h3FFFF, 1'b0, "R4");
    command(2'b10, 32'd0, "R6");
    send(32'h30010, 1'b0, "R2");

    // R9: span boundary
    command(2'b01, 32'h38000, "R9");
    command(2'b01, 32'h38001, "R9");
    command(2'b01, 32'h20000, "R9");
    command(2'b01, 32'h3FFFF, "R9");

    // R8: moved range, and protected range over VGA window (R5 precedence)
    command(2'b00, 32'h50000, "R8");
    command(2'b01, 32'h5FFFF, "R8");
    send(32'h50000, 1'b0, "R8");
    send(32'h30000, 1'b0, "R8");
    command(2'b00, 32'hA0000, "R8");
    command(2'b01, 32'hAFFFF, "R8");
    send(32'hA0100, 1'b1, "R5");
    send(32'hB0000, 1'b0, "R5");
    command(2'b00, 32'h30000, "R8");
    command(2'b01, 32'h3FFFF, "R8");

    // R10: backpressure on DRAM
    dram_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h12340; priv_mode = 1'b0; req_we = 1'b1; req_wdata = 32'hCAFE0001;
    @(negedge clk);
    req_addr = 32'h30000; req_wdata = 32'h0;
    for (int i = 0; i < 3; i++) begin
      check(dram_valid && !vga_valid && !req_ready && dram_addr == 32'h12340 &&
            dram_we && dram_wdata == 32'hCAFE0001, "R10", dram_addr, 32'h12340);
      @(negedge clk);
    end
    req_valid = 1'b0;
    dram_ready = 1'b1;
    @(negedge clk);
    check(!dram_valid && !vga_valid, "R10", {30'd0, dram_valid, vga_valid}, 32'd0);

    // R10: backpressure on VGA
    vga_ready = 1'b0;
    send(32'h31000, 1'b0, "R2");
    repeat (2) begin
      @(negedge clk);
      check(vga_valid && !dram_valid && !req_ready && vga_addr == 32'h31000, "R10", vga_addr, 32'h31000);
    end
    vga_ready = 1'b1;
    @(negedge clk);
    check(!vga_valid, "R10", {31'd0, vga_valid}, 32'd0);

    // constrained random phase, lock excluded
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [31:0] a;
      sel = $urandom_range(0, 9);
      if (sel == 0) begin
        command(2'b10, 32'd0, "R6");
      end else if (sel == 1) begin
        command(2'b00, 32'h20000 + ($urandom_range(0, 15) << 12), "R8");
      end else if (sel == 2) begin
        command(2'b01, m_base + $urandom_range(32'h7000, 32'h20000), "R9");
      end else begin
        case ($urandom_range(0, 6))
          0: a = m_base;
          1: a = m_end;
          2: a = m_base - 1;
          3: a = m_end + 1;
          4: a = m_base + 32'h8000;
          5: a = VLO + $urandom_range(0, 32'h1FFFF);
          default: a = $urandom_range(0, 32'hFFFFF);
        endcase
        send(a, $urandom_range(0, 1) == 1, "R2");
      end
    end

    // R7: lock with open set
    if (!m_open) command(2'b10, 32'd0, "R6");
    command(2'b11, 32'd0, "R7");
    send(m_base, 1'b0, "R2");
    send(m_base, 1'b1, "R3");
    command(2'b10, 32'd0, "R6");
    send(m_base, 1'b0, "R6");
    command(2'b00, 32'h0, "R8");
    command(2'b01, 32'hFFFFF, "R8");
    send(m_end + 1, 1'b0, "R8");
    command(2'b11, 32'd0, "R7");
    repeat (5) @(negedge clk);
    check(lock_bit && !open_bit, "R7", {30'd0, lock_bit, open_bit}, 32'd2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule